// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block produces the status that a dual-bank flash array shows to the host while an internal program or erase is running. A single-cycle start pulse begins an operation. The pulse carries the operation kind, the bank and sector it targets, and bit 7 of the word being programmed. An internal cycle counter then holds the operation busy for a fixed, parameterised number of cycles. Program and erase have separate counts.

While the operation runs, the active-low ready/busy output is held low. Any read of the busy bank returns a status word instead of array data:
- bit 7 is a data-polling flag;
- bit 6 is a toggle that flips on every status read;
- bit 2 is a second toggle that flips only while an erase owns the bank.

Reads of the other bank pass the array word through untouched, so code can keep running from that bank. An erase can be paused and later continued. While it is paused, sectors other than the one being erased read normally. A low level on the hardware reset input abandons the operation and returns the block to plain read mode.

The array itself lives outside the block. Its read word arrives on `arr_data` in the same cycle as the read strobe, and the block returns either that word or the status word one cycle later.

Top module: `emb_status_rep`

## Requirements
- R1: After system reset, `ry_by` is 1, `rd_valid` is 0 and `rd_data` is all zeros.
- R2: A start pulse with `start_erase`=0, accepted while idle, drives `ry_by` low from the next cycle for exactly PROG_CYCLES cycles.
- R3: A start pulse with `start_erase`=1, accepted while idle, drives `ry_by` low for exactly ERASE_CYCLES cycles. Cycles spent paused are not counted.
- R4: During an active program, status reads return bit 7 equal to the inverse of `prog_d7`.
- R5: During an active erase, status reads return bit 7 equal to 0.
- R6: Bit 6 of the status word reads 0 on the first status read after a start and then alternates on each status read while the operation is active. Bit 2 alternates on each status read of an erase, whether active or paused. Bit 2 stays 0 during a program.
- R7: A read whose bank field differs from the target's bank field returns `arr_data` unchanged. The bank field is the top BANK_W bits of `rd_loc`.
- R8: Read data appears one cycle after `rd_en`, together with `rd_valid`=1. Whenever `ry_by` is high and no erase is paused, the data is `arr_data`.
- R9: `hw_reset_n` low at a clock edge aborts the operation. `ry_by` is high in the next cycle and reads of the former target bank return array data.
- R10: `sus_req` during an active erase raises `ry_by` in the next cycle and freezes the counter. Reads of other sectors return array data; the sector field is the low SECT_W bits of `rd_loc`. Reads of the erasing sector return bit 7 = 1 with bit 6 held. `res_req` resumes the erase.
- R11: A start pulse while an operation is in progress is ignored. A `sus_req` during a program is ignored.
- R12: In the status word, every bit other than 7, 6 and 2 is 0. Any sector of the target bank returns the status word while the operation is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| hw_reset_n | input | 1 | Hardware reset, active low; aborts any operation |
| start | input | 1 | Single-cycle start of an embedded operation |
| start_erase | input | 1 | 1 = erase, 0 = program |
| start_loc | input | BANK_W+SECT_W | Bank and sector targeted by the operation |
| prog_d7 | input | 1 | Bit 7 of the word being programmed |
| sus_req | input | 1 | Pause the running erase |
| res_req | input | 1 | Continue a paused erase |
| rd_en | input | 1 | Read strobe |
| rd_loc | input | BANK_W+SECT_W | Bank and sector of the read |
| arr_data | input | DATA_W | Array word for the current read |
| rd_data | output | DATA_W | Returned read word |
| rd_valid | output | 1 | Read word valid |
| ry_by | output | 1 | Ready (1) / busy (0) |

## Verification
The paused-erase case is the hardest to reach from the ports. To get there, an erase must be started, status reads made to move both toggles, and the pause requested before the counter expires. Reads must then go to the erasing sector and to a sibling sector of the same bank, and the erase resumed so that the total busy time can be checked against ERASE_CYCLES. The bench drives this sequence directly and tracks the expected toggle values itself. It then runs seeded random program and erase operations with random targets, data and array words.

// File: rtl/esr_pkg.sv
package esr_pkg;
   typedef enum logic [1:0] {
      ESR_IDLE = 2'd0,
      ESR_RUN  = 2'd1,
      ESR_HOLD = 2'd2
   } esr_state_e;

   // Bit positions of the status flags inside the returned word.
   localparam int POLL_POS = 7;
   localparam int TOGA_POS = 6;
   localparam int TOGB_POS = 2;
endpackage

// File: rtl/esr_busy_timer.sv
module esr_busy_timer #(
   parameter int PROG_CYCLES  = 16,
   parameter int ERASE_CYCLES = 48
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic load_erase,
   input  logic step,
   output logic expired
);
   localparam int MAX_CYC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
   localparam int CNT_W   = $clog2(MAX_CYC);
   localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_erase ? ERASE_LOAD : PROG_LOAD;
      else if (step && (cnt_q != '0))
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/esr_loc_match.sv
module esr_loc_match #(
   parameter int BANK_W = 1,
   parameter int SECT_W = 3
) (
   input  logic [BANK_W+SECT_W-1:0] probe,
   input  logic [BANK_W+SECT_W-1:0] target,
   output logic                     bank_hit,
   output logic                     sect_hit
);
   localparam int LOC_W = BANK_W + SECT_W;

   assign bank_hit = (probe[LOC_W-1:SECT_W] == target[LOC_W-1:SECT_W]);
   assign sect_hit = bank_hit && (probe[SECT_W-1:0] == target[SECT_W-1:0]);
endmodule

// File: rtl/esr_status_word.sv
module esr_status_word
   import esr_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              poll,
   input  logic              tog_a,
   input  logic              tog_b,
   output logic [DATA_W-1:0] word
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      if (b == POLL_POS) begin : g_poll
         assign word[b] = poll;
      end else if (b == TOGA_POS) begin : g_toga
         assign word[b] = tog_a;
      end else if (b == TOGB_POS) begin : g_togb
         assign word[b] = tog_b;
      end else begin : g_zero
         assign word[b] = 1'b0;
      end
   end
endmodule

// File: rtl/emb_status_rep.sv
module emb_status_rep
   import esr_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int BANK_W       = 1,
   parameter int SECT_W       = 3,
   parameter int PROG_CYCLES  = 16,
   parameter int ERASE_CYCLES = 48
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hw_reset_n,
   input  logic                     start,
   input  logic                     start_erase,
   input  logic [BANK_W+SECT_W-1:0] start_loc,
   input  logic                     prog_d7,
   input  logic                     sus_req,
   input  logic                     res_req,
   input  logic                     rd_en,
   input  logic [BANK_W+SECT_W-1:0] rd_loc,
   input  logic [DATA_W-1:0]        arr_data,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     rd_valid,
   output logic                     ry_by
);
   localparam int LOC_W = BANK_W + SECT_W;

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must hold the status bits");
   end
   if (PROG_CYCLES < 2 || ERASE_CYCLES < 2) begin : g_bad_cycles
      $error("busy counts must be at least 2");
   end
   if (BANK_W < 1 || SECT_W < 1) begin : g_bad_loc
      $error("bank and sector fields need at least one bit");
   end

   esr_state_e        state_q, state_d;
   logic [LOC_W-1:0]  tgt_q;
   logic              erase_q, poll_q, toga_q, togb_q;
   logic              is_idle, is_run, is_hold, accept, expired;
   logic              bank_hit, sect_hit, show_status, poll_bit;
   logic [DATA_W-1:0] status_word;

   assign is_idle = (state_q == ESR_IDLE);
   assign is_run  = (state_q == ESR_RUN);
   assign is_hold = (state_q == ESR_HOLD);
   assign accept  = start && hw_reset_n && is_idle;

   esr_busy_timer #(
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_CYCLES(ERASE_CYCLES)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_erase(start_erase),
      .step      (is_run),
      .expired   (expired)
   );

   esr_loc_match #(
      .BANK_W(BANK_W),
      .SECT_W(SECT_W)
   ) u_match (
      .probe   (rd_loc),
      .target  (tgt_q),
      .bank_hit(bank_hit),
      .sect_hit(sect_hit)
   );

   assign poll_bit    = is_run ? (~erase_q & poll_q) : 1'b1;
   assign show_status = rd_en && bank_hit && (is_run || (is_hold && sect_hit));

   esr_status_word #(.DATA_W(DATA_W)) u_word (
      .poll (poll_bit),
      .tog_a(toga_q),
      .tog_b(togb_q),
      .word (status_word)
   );

   always_comb begin
      state_d = state_q;
      if (!hw_reset_n) begin
         state_d = ESR_IDLE;
      end else begin
         unique case (state_q)
            ESR_IDLE: if (start) state_d = ESR_RUN;
            ESR_RUN: begin
               if (expired)                state_d = ESR_IDLE;
               else if (sus_req && erase_q) state_d = ESR_HOLD;
            end
            ESR_HOLD: if (res_req) state_d = ESR_RUN;
            default:  state_d = ESR_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ESR_IDLE;
         tgt_q   <= '0;
         erase_q <= 1'b0;
         poll_q  <= 1'b0;
         toga_q  <= 1'b0;
         togb_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            tgt_q   <= start_loc;
            erase_q <= start_erase;
            poll_q  <= ~prog_d7;
            toga_q  <= 1'b0;
            togb_q  <= 1'b0;
         end else if (show_status) begin
            if (is_run)  toga_q <= ~toga_q;
            if (erase_q) togb_q <= ~togb_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en) rd_data <= show_status ? status_word : arr_data;
      end
   end

   assign ry_by = ~is_run;
endmodule

// File: rtl/esr_status_chk.sv
module esr_status_chk
   import esr_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hw_reset_n,
   input logic              start,
   input logic              rd_en,
   input logic [DATA_W-1:0] arr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              rd_valid,
   input logic              ry_by,
   input logic              st_idle,
   input logic              st_hold,
   input logic              bank_hit,
   input logic              erase_q,
   input logic              poll_q
);
   localparam logic [DATA_W-1:0] FLAG_MASK =
      (DATA_W'(1) << POLL_POS) | (DATA_W'(1) << TOGA_POS) | (DATA_W'(1) << TOGB_POS);

   a_r1_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   a_r1_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (start && hw_reset_n && st_idle) |=> !ry_by);
   a_r4_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !ry_by && bank_hit && !erase_q) |=> (rd_data[POLL_POS] == $past(poll_q)));
   a_r5_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !ry_by && bank_hit && erase_q) |=> !rd_data[POLL_POS]);
   a_r7_other_bank: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !bank_hit) |=> (rd_data == $past(arr_data)));
   a_r8_ready_pass: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && ry_by && !st_hold) |=> (rd_data == $past(arr_data)));
   a_r9_hw_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_reset_n |=> (ry_by && st_idle));
   a_r10_hold_erase: assert property (@(posedge clk) disable iff (!rst_n)
      st_hold |-> erase_q);
   a_r12_flag_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !ry_by && bank_hit) |=> ((rd_data & ~FLAG_MASK) == '0));
endmodule

bind emb_status_rep esr_status_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hw_reset_n(hw_reset_n),
   .start     (start),
   .rd_en     (rd_en),
   .arr_data  (arr_data),
   .rd_data   (rd_data),
   .rd_valid  (rd_valid),
   .ry_by     (ry_by),
   .st_idle   (is_idle),
   .st_hold   (is_hold),
   .bank_hit  (bank_hit),
   .erase_q   (erase_q),
   .poll_q    (poll_q)
);

// File: tb/test_emb_status_rep.sv
module test_emb_status_rep;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 16;
   localparam int LW = 4;
   localparam int PCYC = 16;
   localparam int ECYC = 48;

   logic clk = 1'b0;
   logic rst_n = 1'b0, hw_reset_n = 1'b1;
   logic start = 1'b0, start_erase = 1'b0, prog_d7 = 1'b0;
   logic [LW-1:0] start_loc = '0, rd_loc = '0;
   logic sus_req = 1'b0, res_req = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] arr_data = '0;
   logic [DW-1:0] rd_data;
   logic rd_valid, ry_by;

   int n_checks = 0, n_fail = 0, lows = 0;

   emb_status_rep #(.DATA_W(DW), .BANK_W(1), .SECT_W(3),
                    .PROG_CYCLES(PCYC), .ERASE_CYCLES(ECYC)) i_emb_status_rep (
      .clk(clk), .rst_n(rst_n), .hw_reset_n(hw_reset_n), .start(start),
      .start_erase(start_erase), .start_loc(start_loc), .prog_d7(prog_d7),
      .sus_req(sus_req), .res_req(res_req), .rd_en(rd_en), .rd_loc(rd_loc),
      .arr_data(arr_data), .rd_data(rd_data), .rd_valid(rd_valid), .ry_by(ry_by));

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) if (!ry_by) lows++;

   function automatic logic [DW-1:0] sw(input logic p, input logic a, input logic b);
      return (DW'(p) << 7) | (DW'(a) << 6) | (DW'(b) << 2);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [LW-1:0] loc, input logic [DW-1:0] arr, output logic [DW-1:0] q);
      @(negedge clk); rd_en = 1'b1; rd_loc = loc; arr_data = arr;
      @(negedge clk); rd_en = 1'b0; q = rd_data;
   endtask

   task automatic start_op(input logic er, input logic [LW-1:0] loc, input logic d7);
      @(negedge clk); start = 1'b1; start_erase = er; start_loc = loc; prog_d7 = d7;
      @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_sus();
      @(negedge clk); sus_req = 1'b1;
      @(negedge clk); sus_req = 1'b0;
   endtask

   task automatic pulse_res();
      @(negedge clk); res_req = 1'b1;
      @(negedge clk); res_req = 1'b0;
   endtask

   task automatic wait_ready();
      while (ry_by == 1'b0) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [DW-1:0] q;
      int l0;
      void'($urandom(32'h5EED));
      repeat (3) @(negedge clk);
      chk("R1 ry_by in reset", ry_by, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rd_valid after reset", rd_valid, 0);
      chk("R1 rd_data after reset", rd_data, 0);

      // Program in bank 0, data bit 7 = 1
      l0 = lows;
      start_op(1'b0, 4'h2, 1'b1);
      chk("R2 busy after program start", ry_by, 0);
      rd(4'h5, 16'h1234, q); chk("R4 R6 program status read 1", q, sw(0, 0, 0));
      chk("R8 rd_valid with data", rd_valid, 1);
      rd(4'h2, 16'h1234, q); chk("R6 R12 program status read 2", q, sw(0, 1, 0));
      rd(4'hA, 16'hBEEF, q); chk("R7 other bank during program", q, 16'hBEEF);
      pulse_sus(); chk("R11 suspend ignored in program", ry_by, 0);
      start_op(1'b1, 4'hC, 1'b0); chk("R11 start ignored while busy", ry_by, 0);
      rd(4'h0, 16'hFFFF, q); chk("R11 R4 status unchanged by ignored start", q, sw(0, 0, 0));
      wait_ready();
      chk("R2 program busy length", lows - l0, PCYC);
      rd(4'h2, 16'hC0DE, q); chk("R8 array after program", q, 16'hC0DE);

      // Erase bank 1 sector 3 with a pause
      l0 = lows;
      start_op(1'b1, 4'hB, 1'b1);
      rd(4'hD, 16'h0F0F, q); chk("R5 R6 erase status read 1", q, sw(0, 0, 0));
      rd(4'hD, 16'h0F0F, q); chk("R5 R6 erase status read 2", q, sw(0, 1, 1));
      rd(4'h3, 16'h5555, q); chk("R7 other bank during erase", q, 16'h5555);
      pulse_sus(); chk("R10 ready while paused", ry_by, 1);
      rd(4'hD, 16'hA5A5, q); chk("R10 sibling sector reads array", q, 16'hA5A5);
      rd(4'hB, 16'hA5A5, q); chk("R10 erasing sector status 1", q, sw(1, 0, 0));
      rd(4'hB, 16'hA5A5, q); chk("R10 R6 erasing sector status 2", q, sw(1, 0, 1));
      pulse_res(); chk("R10 busy after resume", ry_by, 0);
      rd(4'h8, 16'h7777, q); chk("R12 R6 status after resume", q, sw(0, 0, 0));
      wait_ready();
      chk("R3 erase busy length excludes pause", lows - l0, ECYC);
      rd(4'hB, 16'h9999, q); chk("R8 array after erase", q, 16'h9999);

      // Hardware reset abort
      start_op(1'b1, 4'h8, 1'b0);
      rd(4'h9, 16'h1111, q); chk("R5 status before abort", q, sw(0, 0, 0));
      @(negedge clk); hw_reset_n = 1'b0;
      @(negedge clk); hw_reset_n = 1'b1;
      chk("R9 ready after abort", ry_by, 1);
      rd(4'h8, 16'h2222, q); chk("R9 array after abort", q, 16'h2222);

      // Seeded random operations
      for (int k = 0; k < 10; k++) begin
         logic er, d7;
         logic [LW-1:0] loc, other;
         logic [DW-1:0] arr;
         er = 1'($urandom); d7 = 1'($urandom);
         loc = LW'($urandom); arr = DW'($urandom);
         other = {~loc[LW-1], 3'($urandom)};
         l0 = lows;
         start_op(er, loc, d7);
         rd({loc[LW-1], 3'($urandom)}, arr, q);
         chk(er ? "R5 random erase status" : "R4 random program status",
             q, sw(er ? 1'b0 : ~d7, 0, 0));
         rd(other, arr ^ 16'hFFFF, q); chk("R7 random other bank", q, arr ^ 16'hFFFF);
         wait_ready();
         chk(er ? "R3 random erase length" : "R2 random program length",
             lows - l0, er ? ECYC : PCYC);
         rd(loc, arr, q); chk("R8 random array after done", q, arr);
      end

      finish_run();
   end
endmodule